// File: doc/BRIEF.md
# Partial-Reconfiguration Engine Register Interface

This block is the device-side register front end of a partial-reconfiguration engine. Software reaches it through 64-bit registers. It uses the registers to run a fixed sequence. First it pulses an engine reset through a request/acknowledge handshake. Then it picks a target region and raises a start request. Next it pushes the image one 32-bit word at a time under credit-based flow control. Finally it marks the push as complete and waits until hardware drops the start bit.

Accepted words go into an internal queue. They leave on a valid/ready stream toward a configuration sink. The sink reports back with a done pulse and three error flags. The block holds those flags, together with its own protocol and overflow faults, in an error register. Software clears that register by writing ones to the bits it wants cleared. A header register and two interface-identifier registers return constants fixed by parameters.

Top module: `pr_engine_regs`

## Requirements
- R1: After reset the status register reads free credits equal to the queue depth (256) in bits 8:0, with bit 16 (busy), bits 22:20 (controller code) and bits 27:24 (host code) all zero. The control register and the error register read zero, and `cfg_valid` is low.
- R2: Writing control bit 0 = 1 enters the reset phase. In this phase controller code is 1, busy is 1 and start (bit 12) reads 0. Control bit 4 (acknowledge) then reads 1. The queue is emptied, so credits return to 256. Writing bit 0 = 0 clears the acknowledge and returns to idle, where busy and controller code read 0.
- R3: A control write with bit 12 = 1 while idle sets start, and busy reads 1 with controller code 2. While start is set, a control write with bit 12 = 0 leaves it set.
- R4: Each data-register write (offset 0x18) made while start is set and credits are non-zero queues bits 31:0 of the write and lowers credits by one. Words leave on `cfg_word` in write order, and bits 63:32 are discarded.
- R5: Each word the sink takes (`cfg_valid` and `cfg_ready` both high at a clock edge) returns one credit. Credits never exceed the queue depth.
- R6: A data write made while start is set and credits are zero sets error bit 4. The word is dropped, and credits stay at zero.
- R7: A data write made while start is clear sets error bit 3. No word is queued, so credits and `cfg_valid` are unchanged.
- R8: A control write with bit 13 = 1 while started sets complete (bit 13) and controller code 3. Start and complete both clear, and the engine goes idle, only on a `cfg_done` pulse that arrives while the queue is empty. A `cfg_done` pulse that arrives with words still queued is ignored.
- R9: A high `cfg_err[2:0]` sets error bits 2:0 (bit 0 operation, bit 1 CRC, bit 2 incompatible image). All error bits are sticky. A write to the error register (offset 0x20) clears exactly the bits written as 1.
- R10: Offsets 0x00, 0xA8 and 0xB0 return the parameters HDR_VALUE, ID_HIGH and ID_LOW. Writes to these offsets change nothing.
- R11: Control bits 9:7 (the region) take the written value only on a control write made while idle that does not request reset. The region reads back in those bits and drives `pr_region`. Writes made while busy leave it unchanged.
- R12: Status bits 27:24 read 1 while the queue holds at least one word and 0 when it is empty. Offsets that are not mapped read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for both read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| cfg_valid | output | 1 | Queued word available to the sink |
| cfg_ready | input | 1 | Sink accepts the word |
| cfg_word | output | 32 | Word at the head of the queue |
| cfg_done | input | 1 | Sink pulse: configuration finished |
| cfg_err | input | 3 | Sink error flags: bit 0 operation, 1 CRC, 2 incompatible image |
| pr_region | output | 3 | Region selected for reconfiguration |

## Verification
The overflow fault is the hardest case to reach from the ports. It only occurs when all 256 credits are used up while the sink holds back. The stimulus keeps `cfg_ready` low and then writes exactly enough words to drive credits to zero. One further write should then set the overflow bit without being queued. Draining the full queue afterwards checks both the order of all queued words and that the dropped word never appears. The completion rule needs a second delicate setup: a `cfg_done` pulse is sent while words are still queued, and it must not release start.

// File: rtl/pr_pkg.sv
package pr_pkg;

  localparam logic [7:0] OFS_HDR  = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_DATA = 8'h18;
  localparam logic [7:0] OFS_ERR  = 8'h20;
  localparam logic [7:0] OFS_IDH  = 8'hA8;
  localparam logic [7:0] OFS_IDL  = 8'hB0;

  localparam int C_RST   = 0;
  localparam int C_ACK   = 4;
  localparam int C_REG_L = 7;
  localparam int C_START = 12;
  localparam int C_CMPL  = 13;

  localparam int S_BUSY  = 16;
  localparam int S_CODE  = 20;
  localparam int S_HOST  = 24;

  localparam int ERR_W   = 5;
  localparam int E_PROTO = 3;
  localparam int E_OVF   = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RST  = 3'd1,
    ST_RUN  = 3'd2,
    ST_FIN  = 3'd3
  } pr_state_e;

endpackage

// File: rtl/pr_word_queue.sv
module pr_word_queue #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic              not_empty,
  output logic              full,
  output logic [CW-1:0]     fill
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full      = (fill == CW'(DEPTH));
  assign not_empty = (fill != '0);
  assign do_push   = push && !full && !flush;
  assign do_pop    = pop && not_empty && !flush;
  assign head_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/pr_seq_ctrl.sv
module pr_seq_ctrl
  import pr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_wr,
  input  logic      want_rst,
  input  logic      want_start,
  input  logic      want_cmpl,
  input  logic [2:0] want_region,
  input  logic      queue_empty,
  input  logic      cfg_done,
  output pr_state_e state,
  output logic      ack,
  output logic [2:0] region,
  output logic      done_evt
);

  pr_state_e state_n;

  assign done_evt = (state == ST_FIN) && queue_empty && cfg_done;

  always_comb begin
    state_n = state;
    if (ctrl_wr && want_rst) begin
      state_n = ST_RST;
    end else begin
      unique case (state)
        ST_RST:  if (ctrl_wr)                state_n = ST_IDLE;
        ST_IDLE: if (ctrl_wr && want_start)  state_n = ST_RUN;
        ST_RUN:  if (ctrl_wr && want_cmpl)   state_n = ST_FIN;
        ST_FIN:  if (done_evt)               state_n = ST_IDLE;
        default:                             state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ack    <= 1'b0;
      region <= '0;
    end else begin
      state <= state_n;
      ack   <= (state == ST_RST) && (state_n == ST_RST);
      if (ctrl_wr && !want_rst && state == ST_IDLE) region <= want_region;
    end
  end

endmodule

// File: rtl/pr_err_hold.sv
module pr_err_hold #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] err
);

  always_ff @(posedge clk) begin
    if (!rst_n) err <= '0;
    else        err <= (clr_wr ? (err & ~clr_mask) : err) | set_vec;
  end

endmodule

// File: rtl/pr_engine_regs.sv
module pr_engine_regs
  import pr_pkg::*;
#(
  parameter int          DEPTH     = 256,
  parameter logic [63:0] HDR_VALUE = 64'h3000_0000_1000_0005,
  parameter logic [63:0] ID_HIGH   = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] ID_LOW    = 64'hFEDC_BA98_7654_3210
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  output logic [31:0] cfg_word,
  input  logic        cfg_done,
  input  logic [2:0]  cfg_err,
  output logic [2:0]  pr_region
);

  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [CW-1:0] credits_left(input logic [CW-1:0] used);
    return CW'(DEPTH) - used;
  endfunction

  function automatic logic [63:0] pack_status(input logic [CW-1:0] cred,
                                              input logic busy_f,
                                              input logic [2:0] code,
                                              input logic [3:0] host);
    logic [63:0] v;
    v = 64'(cred);
    v[S_BUSY] = busy_f;
    v[S_CODE +: 3] = code;
    v[S_HOST +: 4] = host;
    return v;
  endfunction

  // named internal events
  logic            ctrl_wr, data_wr, err_wr;
  logic            start_q, rst_active, busy, ack_q, done_evt;
  logic            push_ok, pop_evt, ovf_evt, proto_evt;
  logic            q_full;
  logic [CW-1:0]   q_fill, credits;
  logic [2:0]      region_q;
  logic [ERR_W-1:0] err_q;
  pr_state_e       state;
  logic            wdata_hi_unused;

  assign wdata_hi_unused = ^reg_wdata[63:32];

  assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
  assign data_wr = reg_wr && (reg_addr == OFS_DATA);
  assign err_wr  = reg_wr && (reg_addr == OFS_ERR);

  assign rst_active = (state == ST_RST);
  assign start_q    = (state == ST_RUN) || (state == ST_FIN);
  assign busy       = (state != ST_IDLE);

  assign push_ok   = data_wr && start_q && !q_full;
  assign ovf_evt   = data_wr && start_q && q_full;
  assign proto_evt = data_wr && !start_q;
  assign pop_evt   = cfg_valid && cfg_ready;
  assign credits   = credits_left(q_fill);
  assign pr_region = region_q;

  pr_seq_ctrl u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .want_rst    (reg_wdata[C_RST]),
    .want_start  (reg_wdata[C_START]),
    .want_cmpl   (reg_wdata[C_CMPL]),
    .want_region (reg_wdata[C_REG_L +: 3]),
    .queue_empty (!cfg_valid),
    .cfg_done    (cfg_done),
    .state       (state),
    .ack         (ack_q),
    .region      (region_q),
    .done_evt    (done_evt)
  );

  pr_word_queue #(.DEPTH(DEPTH), .WORD_W(32)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rst_active),
    .push      (push_ok),
    .push_word (reg_wdata[31:0]),
    .pop       (cfg_ready),
    .head_word (cfg_word),
    .not_empty (cfg_valid),
    .full      (q_full),
    .fill      (q_fill)
  );

  pr_err_hold #(.W(ERR_W)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  ({ovf_evt, proto_evt, cfg_err}),
    .clr_wr   (err_wr),
    .clr_mask (reg_wdata[ERR_W-1:0]),
    .err      (err_q)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_HDR:  reg_rdata = HDR_VALUE;
      OFS_IDH:  reg_rdata = ID_HIGH;
      OFS_IDL:  reg_rdata = ID_LOW;
      OFS_CTRL: begin
        reg_rdata[C_RST]       = rst_active;
        reg_rdata[C_ACK]       = ack_q;
        reg_rdata[C_REG_L +: 3] = region_q;
        reg_rdata[C_START]     = start_q;
        reg_rdata[C_CMPL]      = (state == ST_FIN);
      end
      OFS_STAT: reg_rdata = pack_status(credits, busy, state, {3'b000, cfg_valid});
      OFS_ERR:  reg_rdata = 64'(err_q);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pr_engine_checker.sv
module pr_engine_checker #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] credits,
  input logic          ack_q,
  input logic          rst_active,
  input logic          ovf_evt,
  input logic          proto_evt,
  input logic [4:0]    err_q,
  input logic          start_q,
  input logic          done_evt,
  input logic          busy,
  input logic [2:0]    region_q,
  input logic          push_ok,
  input logic          pop_evt
);

  assert_credit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CW'(DEPTH));

  assert_ack_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> rst_active);

  assert_overflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> err_q[4]);

  assert_protocol_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_evt |=> err_q[3]);

  assert_start_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> ($past(done_evt) || rst_active));

  assert_region_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(region_q));

  assert_push_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_evt && !rst_active) |=> (credits == $past(credits) - 1'b1));

endmodule

bind pr_engine_regs pr_engine_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .credits    (credits),
  .ack_q      (ack_q),
  .rst_active (rst_active),
  .ovf_evt    (ovf_evt),
  .proto_evt  (proto_evt),
  .err_q      (err_q),
  .start_q    (start_q),
  .done_evt   (done_evt),
  .busy       (busy),
  .region_q   (region_q),
  .push_ok    (push_ok),
  .pop_evt    (pop_evt)
);

// File: tb/pr_engine_regs_test.sv
module pr_engine_regs_test;

  localparam logic [63:0] HDR = 64'h3000_0000_1000_0005;
  localparam logic [63:0] IDH = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] IDL = 64'hFEDC_BA98_7654_3210;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        cfg_valid;
  logic        cfg_ready = 1'b0;
  logic [31:0] cfg_word;
  logic        cfg_done = 1'b0;
  logic [2:0]  cfg_err = 3'b000;
  logic [2:0]  pr_region;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [31:0] model [0:511];
  int m_head = 0;
  int m_tail = 0;

  always #4 clk = ~clk;

  pr_engine_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_word(cfg_word), .cfg_done(cfg_done),
    .cfg_err(cfg_err), .pr_region(pr_region)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] stat_exp(input int cred, input bit bsy,
                                           input int code, input int host);
    return 64'(cred) | (64'(bsy) << 16) | (64'(code) << 20) | (64'(host) << 24);
  endfunction

  task automatic push_word(input logic [31:0] w);
    wr(8'h18, {32'hDEAD_BEEF, w});
    model[m_tail] = w;
    m_tail++;
  endtask

  task automatic drain_all(input string tag);
    @(negedge clk);
    cfg_ready = 1'b1;
    while (cfg_valid) begin
      check(tag, {32'h0, cfg_word}, {32'h0, model[m_head]});
      m_head++;
      @(negedge clk);
    end
    cfg_ready = 1'b0;
    check({tag, " count"}, 64'(m_head), 64'(m_tail));
  endtask

  task automatic t_reset_state;
    logic [63:0] v;
    rd(8'h10, v); check("R1 status", v, stat_exp(256, 0, 0, 0));
    rd(8'h08, v); check("R1 ctrl", v, 64'h0);
    rd(8'h20, v); check("R1 err", v, 64'h0);
    check("R1 valid", 64'(cfg_valid), 64'h0);
    rd(8'h40, v); check("R12 unmapped", v, 64'h0);
  endtask

  task automatic t_ids;
    logic [63:0] v;
    wr(8'h00, 64'h1111); wr(8'hA8, 64'h2222); wr(8'hB0, 64'h3333);
    rd(8'h00, v); check("R10 header", v, HDR);
    rd(8'hA8, v); check("R10 id high", v, IDH);
    rd(8'hB0, v); check("R10 id low", v, IDL);
  endtask

  task automatic t_protocol;
    logic [63:0] v;
    wr(8'h18, 64'h5555);
    rd(8'h20, v); check("R7 proto bit", v, 64'h08);
    rd(8'h10, v); check("R7 credits", v, stat_exp(256, 0, 0, 0));
    check("R7 valid", 64'(cfg_valid), 64'h0);
    wr(8'h20, 64'h08);
    rd(8'h20, v); check("R9 w1c", v, 64'h0);
  endtask

  task automatic t_start;
    logic [63:0] v;
    wr(8'h08, 64'h280);
    rd(8'h08, v); check("R11 region idle", v, 64'h280);
    check("R11 pin", 64'(pr_region), 64'd5);
    wr(8'h08, 64'h1280);
    rd(8'h08, v); check("R3 start", v, 64'h1280);
    rd(8'h10, v); check("R3 status", v, stat_exp(256, 1, 2, 0));
    wr(8'h08, 64'h0100);
    rd(8'h08, v); check("R3 start kept R11 region kept", v, 64'h1280);
  endtask

  task automatic t_push_pop;
    logic [63:0] v;
    for (int i = 0; i < 3; i++) push_word(32'hA000_0000 + i);
    rd(8'h10, v); check("R4 R12 credits", v, stat_exp(253, 1, 2, 1));
    check("R4 head", 64'(cfg_word), 64'h0A000_0000);
    @(negedge clk); cfg_ready = 1'b1;
    @(negedge clk); cfg_ready = 1'b0;
    m_head++;
    rd(8'h10, v); check("R5 credit back", v, stat_exp(254, 1, 2, 1));
    check("R5 next head", 64'(cfg_word), 64'h0A000_0001);
  endtask

  task automatic t_overflow;
    logic [63:0] v;
    for (int i = 0; i < 254; i++) push_word(32'hB000_0000 + i);
    rd(8'h10, v); check("R6 credits zero", v, stat_exp(0, 1, 2, 1));
    wr(8'h18, 64'hFFFF_FFFF);
    rd(8'h20, v); check("R6 overflow bit", v, 64'h10);
    rd(8'h10, v); check("R6 credits stay", v, stat_exp(0, 1, 2, 1));
    drain_all("R4 R6 order");
    rd(8'h10, v); check("R5 R12 drained", v, stat_exp(256, 1, 2, 0));
  endtask

  task automatic t_sink_err;
    logic [63:0] v;
    @(negedge clk); cfg_err = 3'b010;
    @(negedge clk); cfg_err = 3'b000;
    rd(8'h20, v); check("R9 crc set", v, 64'h12);
    wr(8'h20, 64'h02);
    rd(8'h20, v); check("R9 partial clear", v, 64'h10);
    @(negedge clk); cfg_err = 3'b101;
    @(negedge clk); cfg_err = 3'b000;
    wr(8'h20, 64'h15);
    rd(8'h20, v); check("R9 clear all", v, 64'h0);
  endtask

  task automatic t_complete;
    logic [63:0] v;
    push_word(32'hC0DE_0001);
    wr(8'h08, 64'h3280);
    rd(8'h08, v); check("R8 complete set", v, 64'h3280);
    rd(8'h10, v); check("R8 code", v, stat_exp(255, 1, 3, 1));
    @(negedge clk); cfg_done = 1'b1;
    @(negedge clk); cfg_done = 1'b0;
    rd(8'h08, v); check("R8 early done ignored", v, 64'h3280);
    drain_all("R8 drain");
    @(negedge clk); cfg_done = 1'b1;
    @(negedge clk); cfg_done = 1'b0;
    rd(8'h08, v); check("R8 released", v, 64'h0280);
    rd(8'h10, v); check("R8 idle", v, stat_exp(256, 0, 0, 0));
  endtask

  task automatic t_reset_hs;
    logic [63:0] v;
    bit got;
    wr(8'h08, 64'h1280);
    push_word(32'hD000_0001);
    push_word(32'hD000_0002);
    wr(8'h08, 64'h1281);
    got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      rd(8'h08, v);
      if (v[4]) got = 1;
      else @(negedge clk);
    end
    check("R2 ack", 64'(got), 64'h1);
    rd(8'h08, v); check("R2 ctrl in reset", v, 64'h0291);
    rd(8'h10, v); check("R2 status in reset", v, stat_exp(256, 1, 1, 0));
    m_head = m_tail;
    wr(8'h08, 64'h0);
    rd(8'h08, v); check("R2 ack cleared", v, 64'h0280);
    rd(8'h10, v); check("R2 idle", v, stat_exp(256, 0, 0, 0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ids();
    t_protocol();
    t_start();
    t_push_pop();
    t_overflow();
    t_sink_err();
    t_complete();
    t_reset_hs();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule